// File: doc/BRIEF.md
# Display Control Register Decoder

This block receives 32-bit writes on a display control port. It turns them into the registered display state that a video output stage reads. The top byte of each write picks a command and the lower bits carry its arguments. The block holds the following state:

- the display start position;
- the horizontal and vertical capture ranges;
- the packed display-mode field;
- the blanking flag;
- the DMA direction.

From this state it builds a 32-bit status word and works out the visible picture width and height. It also serves info-request commands through a readback register, and it pulses a clear line toward an external command FIFO.

Visible width is the horizontal span scaled by the mode's horizontal resolution over a 2560-count dot-clock range. A small restoring divider computes it over several cycles. A busy/valid pair tells the consumer when width and height match the programmed state. Drawing, video timing and command storage live elsewhere.

Top module: `dispctl_top`

## Requirements
- R1: After reset the outputs are as follows: statusWord is 0x14802000, readback is 0, blank is 1, dmaDir is 0, startX and startY are 0, visWidth is 256, visHeight is 240, busy and fifoClr are 0, and dimValid is 1.
- R2: Command 0x03 copies data bit 0 to blank and to status bit 23. Command 0x04 copies data bits 1:0 to dmaDir and to status bits 30:29.
- R3: Command 0x05 loads startX from data bits 9:0 and startY from data bits 18:10. Other data bits have no effect.
- R4: Command 0x08 places data bits 5:0 in status bits 22:17 and data bit 6 in status bit 16. The horizontal resolution is indexed by status bits 18:16 in {256,368,320,384,512,512,640,640}. The vertical resolution is indexed by status bits 20:19 in {240,480,256,480}.
- R5: Command 0x06 sets the horizontal range, with the start in bits 11:0 and the end in bits 23:12. Let span be end minus start. If span is at most 0 or at least 2560, visWidth equals the horizontal resolution. Otherwise visWidth is floor(span*hres/2560).
- R6: Command 0x07 sets the vertical range, with the start in bits 9:0 and the end in bits 19:10. The span is end minus start, doubled when status bit 19 is set. If the result is at most 0 or above the vertical resolution, visHeight equals the vertical resolution. Otherwise visHeight equals the result.
- R7: For commands 0x02 to 0x0F other than 0x05, a write whose value equals the last accepted write for that command is ignored. For example, no recomputation starts, so busy stays 0.
- R8: Every command 0x01 write raises fifoClr for exactly one cycle, in the cycle after the write, even when the value repeats.
- R9: Command 0x00 restores the R1 state and clears the positions and ranges. It pulses fifoClr and forgets all last-accepted values, so a previously repeated write is accepted again.
- R10: For commands 0x10 to 0x1F, readback is loaded from the low data nibble. Nibble 7 gives 2. Nibbles 2 to 6 give the low 20 bits of the internal shadow words, which are 0 after reset. Any other nibble gives 0.
- R11: Writes of commands 0x00, 0x06, 0x07 and 0x08 that are not ignored raise busy in the next cycle. Busy falls when visWidth and visHeight are current. dimValid is the inverse of busy. While busy is low, visWidth and visHeight do not change and do not exceed the current resolutions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Control write strobe |
| wrData | input | 32 | Control write word, command in bits 31:24 |
| statusWord | output | 32 | Assembled status word |
| readback | output | 32 | Info-request result |
| startX | output | 10 | Display start X |
| startY | output | 9 | Display start Y |
| blank | output | 1 | Display blanked |
| dmaDir | output | 2 | DMA direction code |
| visWidth | output | 10 | Derived visible width |
| visHeight | output | 10 | Derived visible height |
| busy | output | 1 | Derived dimensions being recomputed |
| dimValid | output | 1 | Derived dimensions current |
| fifoClr | output | 1 | One-cycle command FIFO clear |

## Verification
The checker assumes that wrData carries known values whenever wrEn is high and that reset is synchronous. It also assumes that startX follows any command 0x05 one cycle later, because that command is never filtered. The bench writes only at falling edges, one write per two cycles. Before reading the derived dimensions it waits for busy to drop, so a recomputation is never cut short by a later write. The width and height sweeps walk every resolution index against spans placed on both sides of each clamp boundary.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

  typedef struct packed {
    logic fullRst;
    logic bufRst;
    logic setBlank;
    logic setDma;
    logic setStart;
    logic setHRange;
    logic setVRange;
    logic setMode;
    logic infoReq;
  } ctrlStrb_t;

  localparam logic [31:0] STATUS_INIT = 32'h1480_2000;

  function automatic logic [9:0] hresLookup(input logic [2:0] idx);
    case (idx)
      3'd0: hresLookup = 10'd256;
      3'd1: hresLookup = 10'd368;
      3'd2: hresLookup = 10'd320;
      3'd3: hresLookup = 10'd384;
      3'd4, 3'd5: hresLookup = 10'd512;
      default: hresLookup = 10'd640;
    endcase
  endfunction

  function automatic logic [9:0] vresLookup(input logic [1:0] idx);
    case (idx)
      2'd0: vresLookup = 10'd240;
      2'd2: vresLookup = 10'd256;
      default: vresLookup = 10'd480;
    endcase
  endfunction

endpackage

// File: rtl/dispctl_ctrl.sv
module dispctl_ctrl
  import dispctl_pkg::*;
#(
  parameter int NUM_STORED = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output ctrlStrb_t   strb
);
  localparam int IDXW = $clog2(NUM_STORED);

  logic [31:0] lastVal [NUM_STORED];
  logic [7:0]  cmd;
  logic        isStored;
  logic        dup;
  logic        accept;

  assign cmd      = wrData[31:24];
  assign isStored = (cmd < 8'(NUM_STORED));
  assign dup      = isStored && (cmd > 8'd1) && (cmd != 8'd5) &&
                    (lastVal[cmd[IDXW-1:0]] == wrData);
  assign accept   = wrEn && !dup;

  always_comb begin
    strb           = '0;
    strb.fullRst   = accept && (cmd == 8'h00);
    strb.bufRst    = accept && (cmd == 8'h01);
    strb.setBlank  = accept && (cmd == 8'h03);
    strb.setDma    = accept && (cmd == 8'h04);
    strb.setStart  = accept && (cmd == 8'h05);
    strb.setHRange = accept && (cmd == 8'h06);
    strb.setVRange = accept && (cmd == 8'h07);
    strb.setMode   = accept && (cmd == 8'h08);
    strb.infoReq   = accept && (cmd[7:4] == 4'h1);
  end

  for (genvar i = 0; i < NUM_STORED; i++) begin : g_last
    localparam logic [31:0] INIT = (i == 3) ? 32'd1 : 32'd0;
    always_ff @(posedge clk) begin
      if (!rstN || strb.fullRst)
        lastVal[i] <= INIT;
      else if (accept && isStored && (cmd[IDXW-1:0] == IDXW'(i)))
        lastVal[i] <= wrData;
    end
  end

endmodule

// File: rtl/dispctl_dp.sv
module dispctl_dp
  import dispctl_pkg::*;
#(
  parameter int SPAN    = 2560,
  parameter int XW      = 12,
  parameter int YW      = 10,
  parameter int RESW    = 10,
  parameter int DIVW    = 21,
  parameter int NUM_EXT = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrb_t       strb,
  input  logic [31:0]     wrData,
  output logic [31:0]     statusWord,
  output logic [31:0]     readback,
  output logic [9:0]      startX,
  output logic [8:0]      startY,
  output logic            busy,
  output logic            fifoClr,
  output logic [RESW-1:0] visWidth,
  output logic [RESW-1:0] visHeight
);
  localparam int PRODW = XW + RESW;
  localparam int REMW  = $clog2(SPAN) + 1;
  localparam int CNTW  = $clog2(DIVW + 1);
  localparam int HSW   = YW + 3;

  logic [31:0]      status;
  logic [XW-1:0]    hStart, hEnd;
  logic [YW-1:0]    vStart, vEnd;
  logic             kick, running;
  logic [DIVW-1:0]  dvd;
  logic [REMW-1:0]  rem;
  logic [CNTW-1:0]  cnt;
  logic [31:0]      extShadow [NUM_EXT];

  logic [RESW-1:0]   hres, vres;
  logic signed [XW:0] hSpan;
  logic              fullW;
  logic [PRODW-1:0]  prod;
  logic signed [HSW-1:0] vSpan, vSpanD;
  logic [RESW-1:0]   heightNew;
  logic [REMW-1:0]   remShift;
  logic              qBit;
  logic [DIVW-1:0]   dvdNext;

  assign hres   = hresLookup(status[18:16]);
  assign vres   = vresLookup(status[20:19]);
  assign hSpan  = $signed({1'b0, hEnd}) - $signed({1'b0, hStart});
  assign fullW  = (hSpan <= 0) || (hSpan >= $signed((XW+1)'(SPAN)));
  assign prod   = PRODW'(hSpan[XW-1:0]) * PRODW'(hres);

  assign vSpan  = $signed(HSW'({1'b0, vEnd})) - $signed(HSW'({1'b0, vStart}));
  assign vSpanD = status[19] ? (vSpan <<< 1) : vSpan;
  assign heightNew = ((vSpanD <= 0) || (vSpanD > $signed(HSW'(vres)))) ?
                     vres : vSpanD[RESW-1:0];

  assign remShift = {rem[REMW-2:0], dvd[DIVW-1]};
  assign qBit     = (remShift >= REMW'(SPAN));
  assign dvdNext  = {dvd[DIVW-2:0], qBit};

  assign busy       = kick | running;
  assign statusWord = status;

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
    always_ff @(posedge clk) begin
      if (!rstN || strb.fullRst)
        extShadow[i] <= {8'(8'hE0 + i), 24'd0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.fullRst) begin
      status   <= STATUS_INIT;
      readback <= '0;
      startX   <= '0;
      startY   <= '0;
      hStart   <= '0;
      hEnd     <= '0;
      vStart   <= '0;
      vEnd     <= '0;
    end else begin
      if (strb.setBlank) status[23]    <= wrData[0];
      if (strb.setDma)   status[30:29] <= wrData[1:0];
      if (strb.setMode)  status[22:16] <= {wrData[5:0], wrData[6]};
      if (strb.setStart) begin
        startX <= wrData[9:0];
        startY <= wrData[18:10];
      end
      if (strb.setHRange) begin
        hStart <= wrData[XW-1:0];
        hEnd   <= wrData[2*XW-1:XW];
      end
      if (strb.setVRange) begin
        vStart <= wrData[YW-1:0];
        vEnd   <= wrData[2*YW-1:YW];
      end
      if (strb.infoReq) begin
        case (wrData[3:0])
          4'd2, 4'd3, 4'd4, 4'd5: readback <= {12'd0, extShadow[wrData[2:0]][19:0]};
          4'd6:    readback <= {12'd0, extShadow[5][19:0]};
          4'd7:    readback <= 32'd2;
          default: readback <= '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoClr <= 1'b0;
      kick    <= 1'b0;
    end else begin
      fifoClr <= strb.bufRst | strb.fullRst;
      kick    <= strb.fullRst | strb.setHRange | strb.setVRange | strb.setMode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running   <= 1'b0;
      dvd       <= '0;
      rem       <= '0;
      cnt       <= '0;
      visWidth  <= RESW'(256);
      visHeight <= RESW'(240);
    end else if (kick) begin
      visHeight <= heightNew;
      rem       <= '0;
      dvd       <= prod[DIVW-1:0];
      cnt       <= CNTW'(DIVW);
      running   <= !fullW;
      if (fullW) visWidth <= hres;
    end else if (running) begin
      rem <= qBit ? (remShift - REMW'(SPAN)) : remShift;
      dvd <= dvdNext;
      cnt <= cnt - 1'b1;
      if (cnt == CNTW'(1)) begin
        running  <= 1'b0;
        visWidth <= dvdNext[RESW-1:0];
      end
    end
  end

endmodule

// File: rtl/dispctl_top.sv
module dispctl_top
  import dispctl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] statusWord,
  output logic [31:0] readback,
  output logic [9:0]  startX,
  output logic [8:0]  startY,
  output logic        blank,
  output logic [1:0]  dmaDir,
  output logic [9:0]  visWidth,
  output logic [9:0]  visHeight,
  output logic        busy,
  output logic        dimValid,
  output logic        fifoClr
);
  ctrlStrb_t strb;

  dispctl_ctrl #(.NUM_STORED(16)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .strb(strb)
  );

  dispctl_dp #(.SPAN(2560), .XW(12), .YW(10), .RESW(10), .DIVW(21), .NUM_EXT(8)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .statusWord(statusWord), .readback(readback),
    .startX(startX), .startY(startY), .busy(busy), .fifoClr(fifoClr),
    .visWidth(visWidth), .visHeight(visHeight)
  );

  assign blank    = statusWord[23];
  assign dmaDir   = statusWord[30:29];
  assign dimValid = !busy;

endmodule

// File: rtl/dispctl_chk.sv
module dispctl_chk
  import dispctl_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [31:0] wrData,
  input logic [31:0] statusWord,
  input logic [9:0]  startX,
  input logic [8:0]  startY,
  input logic [9:0]  visWidth,
  input logic [9:0]  visHeight,
  input logic        busy,
  input logic        fifoClr
);
  // R8
  clr_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoClr |-> $past(wrEn));

  // R3
  start_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[31:24] == 8'h05) |=>
      (startX == $past(wrData[9:0]) && startY == $past(wrData[18:10])));

  // R11
  dims_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> ($stable(visWidth) && $stable(visHeight)));

  // R11
  busy_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !wrEn) |=> !busy);

  // R5
  width_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (visWidth <= hresLookup(statusWord[18:16])));

  // R6
  height_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (visHeight <= vresLookup(statusWord[20:19])));

endmodule

bind dispctl_top dispctl_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
  .statusWord(statusWord), .startX(startX), .startY(startY),
  .visWidth(visWidth), .visHeight(visHeight), .busy(busy), .fifoClr(fifoClr)
);

// File: tb/dispctl_top_bench.sv
module dispctl_top_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] statusWord, readback;
  logic [9:0]  startX, visWidth, visHeight;
  logic [8:0]  startY;
  logic        blank, busy, dimValid, fifoClr;
  logic [1:0]  dmaDir;

  int checks = 0;
  int failures = 0;
  logic [31:0] expStat;

  always #(CLK_PERIOD/2) clk = ~clk;

  dispctl_top u_dispctl_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .statusWord(statusWord), .readback(readback), .startX(startX), .startY(startY),
    .blank(blank), .dmaDir(dmaDir), .visWidth(visWidth), .visHeight(visHeight),
    .busy(busy), .dimValid(dimValid), .fifoClr(fifoClr)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  function automatic int hresOf(input int idx);
    int t[8] = '{256, 368, 320, 384, 512, 512, 640, 640};
    return t[idx];
  endfunction

  function automatic int vresOf(input int idx);
    int t[4] = '{240, 480, 256, 480};
    return t[idx];
  endfunction

  function automatic logic [31:0] modeStat(input logic [31:0] s, input logic [6:0] d);
    logic [31:0] r;
    r = s & ~32'h007F_0000;
    r = r | (32'(d[5:0]) << 17) | (32'(d[6]) << 16);
    return r;
  endfunction

  initial begin
    int cycles = 0;
    while (cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 status", statusWord, 32'h1480_2000);
    check("R1 readback", readback, 0);
    check("R1 blank", blank, 1);
    check("R1 dmaDir", dmaDir, 0);
    check("R1 start", {startX, startY}, 0);
    check("R1 width", visWidth, 256);
    check("R1 height", visHeight, 240);
    check("R1 busy/valid/clr", {busy, dimValid, fifoClr}, 3'b010);
    expStat = 32'h1480_2000;

    // R2 blanking and DMA direction
    wr(32'h0300_0000); expStat[23] = 1'b0;
    check("R2 blank off", blank, 0);
    check("R2 status blank", statusWord, expStat);
    for (int d = 0; d < 4; d++) begin
      wr(32'h0400_0000 | 32'(d)); expStat[30:29] = 2'(d);
      check("R2 dmaDir", dmaDir, d);
      check("R2 status dma", statusWord, expStat);
    end
    wr(32'h0300_0001); expStat[23] = 1'b1;
    check("R2 blank on", blank, 1);

    // R3 start position
    wr(32'h05F0_0000 | (32'h1FF << 10) | 32'h3FF);
    check("R3 max x", startX, 10'h3FF);
    check("R3 max y", startY, 9'h1FF);
    wr(32'h0580_0000 | (32'd300 << 10) | 32'd5);
    check("R3 x", startX, 5);
    check("R3 y", startY, 300);

    // R4 and R5 width sweep over every horizontal index
    for (int h = 0; h < 8; h++) begin
      int spans[8] = '{-5, 0, 1, 37, 1280, 2559, 2560, 3000};
      logic [6:0] d;
      d = 7'(((h & 1) << 6) | (h >> 1));
      wr(32'h0800_0000 | 32'(d));
      expStat = modeStat(expStat, d);
      waitIdle();
      check("R4 status mode", statusWord, expStat);
      for (int s = 0; s < 8; s++) begin
        int x1, x2, ew;
        x1 = 500; x2 = 500 + spans[s];
        wr(32'h0600_0000 | (32'(x2) << 12) | 32'(x1));
        waitIdle();
        if (spans[s] <= 0 || spans[s] >= 2560) ew = hresOf(h);
        else ew = (spans[s] * hresOf(h)) / 2560;
        check("R5 width", visWidth, ew);
        check("R11 dimValid", dimValid, 1);
      end
    end

    // R4 and R6 height sweep over every vertical index
    for (int vi = 0; vi < 4; vi++) begin
      int y1s[6] = '{0, 10, 100, 100, 0, 16};
      int y2s[6] = '{0, 250, 340, 99, 600, 256};
      logic [6:0] d;
      d = 7'(vi << 2);
      wr(32'h0800_0000 | 32'(d));
      expStat = modeStat(expStat, d);
      waitIdle();
      check("R4 status vmode", statusWord, expStat);
      for (int k = 0; k < 6; k++) begin
        int sh;
        wr(32'h0700_0000 | (32'(y2s[k]) << 10) | 32'(y1s[k]));
        check("R11 busy after write", busy, 1);
        waitIdle();
        sh = y2s[k] - y1s[k];
        if (vi & 1) sh = sh * 2;
        if (sh <= 0 || sh > vresOf(vi)) sh = vresOf(vi);
        check("R6 height", visHeight, sh);
      end
    end

    // R10 info requests
    wr(32'h1000_0007); check("R10 nibble 7", readback, 2);
    wr(32'h1000_0003); check("R10 nibble 3", readback, 0);
    wr(32'h1F00_0017); check("R10 cmd 0x1F nibble 7", readback, 2);
    wr(32'h1000_0006); check("R10 nibble 6", readback, 0);
    wr(32'h1A00_0007); check("R10 cmd 0x1A", readback, 2);
    wr(32'h1000_000F); check("R10 other nibble", readback, 0);

    // R7 repeated writes are ignored
    v = 32'h0600_0000 | (32'd2000 << 12) | 32'd100;
    wr(v); waitIdle();
    check("R5 width 1900 span", visWidth, (1900 * hresOf(0)) / 2560);
    wr(v);
    check("R7 dup hrange busy", busy, 0);
    wr(32'h0800_0000 | 32'h0C);
    expStat = modeStat(expStat, 7'h0C);
    waitIdle();
    wr(32'h0800_0000 | 32'h0C);
    check("R7 dup mode busy", busy, 0);
    check("R7 dup mode status", statusWord, expStat);

    // R8 buffer clear pulse, also on repeats
    wr(32'h0100_0000);
    check("R8 pulse high", fifoClr, 1);
    @(negedge clk);
    check("R8 pulse low", fifoClr, 0);
    wr(32'h0100_0000);
    check("R8 repeat pulse", fifoClr, 1);
    @(negedge clk);
    check("R8 repeat low", fifoClr, 0);

    // R9 full reset
    wr(32'h0000_0000);
    check("R9 clr pulse", fifoClr, 1);
    check("R9 status", statusWord, 32'h1480_2000);
    check("R9 readback", readback, 0);
    check("R9 start", {startX, startY}, 0);
    waitIdle();
    check("R9 width", visWidth, 256);
    check("R9 height", visHeight, 240);
    wr(v);
    check("R9 repeat accepted busy", busy, 1);
    waitIdle();
    check("R9 width after rewrite", visWidth, (1900 * 256) / 2560);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule